// File: doc/BRIEF.md
# Receive FIFO with Overrun Status

This block sits between a serial byte deserializer and a CPU register port. Each time the deserializer finishes a byte it pulses a strobe. The byte then goes into a 16-entry first-in first-out buffer. The CPU drains the buffer through a data port. The head byte is visible combinationally, and a pop pulse advances the buffer.

When a byte completes while all entries are occupied and no pop happens in that cycle, the block drops the byte and raises an overrun flag. The bytes already held are kept. While the flag is up, reception is stalled: no strobe is accepted, even after the CPU has freed space.

The flag sits at bit 0 of a 16-bit status register. The CPU cannot set it. A write of 0 clears it only after a status read has returned the flag as 1. Any status write uses up that read, whatever value it writes.

Top module: `rx_fifo_ovr`

## Requirements
- R1: Accepted bytes come out of `dat_rdata` in arrival order. `dat_rdata` always shows the oldest stored byte, a `dat_pop` pulse removes it, and `rx_avail` is 1 exactly when at least one byte is stored. Up to 16 bytes are held.
- R2: A strobe with the receiver enabled, the flag at 0, all 16 entries occupied and no pop in the same cycle sets the overrun flag at the next clock edge.
- R3: On overrun the 16 stored bytes remain unchanged and in order, and the byte that caused the overrun is never stored.
- R4: While the overrun flag is 1, strobes store nothing, even when entries are free.
- R5: A status write with bit 0 equal to 1 never sets the flag and never clears it.
- R6: A status write with bit 0 equal to 0 clears the flag only if a status read returned the flag as 1 since the last status write. Any status write consumes that read, so a 0 written without such a read leaves the flag at 1.
- R7: After reset the flag is 0, the buffer is empty, `rx_avail` is 0 and `dat_rdata` is 0.
- R8: While `rx_en` is 0, strobes store nothing and leave the flag unchanged.
- R9: `sts_rdata` bit 0 is the overrun flag. Bits 15 to 1 always read 0, whatever was written.
- R10: A pop and an accepted strobe in the same cycle are both performed, even when the buffer is full. The number of stored bytes stays the same and no overrun occurs.
- R11: A pop while the buffer is empty returns 0 on `dat_rdata` and changes nothing. The next stored byte is the next one read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_en | input | 1 | Receiver enable; strobes are ignored while low |
| rx_strobe | input | 1 | One-cycle pulse when a byte has completed |
| rx_byte | input | 8 | The completed byte |
| dat_pop | input | 1 | CPU reads and removes the head byte |
| dat_rdata | output | 8 | Head byte, 0 when empty |
| rx_avail | output | 1 | At least one byte is stored |
| sts_rd | input | 1 | CPU status register read |
| sts_wr | input | 1 | CPU status register write |
| sts_wdata | input | 16 | Status write data |
| sts_rdata | output | 16 | Status read data, flag at bit 0 |

## Verification
Directed sequences fill the buffer to exactly 16 entries. One sequence then adds a strobe together with a pop, which must not raise the flag. Another adds a strobe without a pop, which must raise the flag and drop the byte. Pops after the overrun, followed by strobes, tell a stall (R4) apart from normal refilling. Three status-port orders separate a correct handshake from a flag that clears on any 0 write or that keeps a stale read across writes: write without a read, read followed by two writes, and read followed by a 0 write. A long random mix of strobes, pops, enable changes and status traffic is compared cycle by cycle with a queue model in the bench.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // next index of a circular buffer of the given depth
  function automatic int unsigned wrap_inc(int unsigned idx, int unsigned depth);
    return (idx + 1 == depth) ? 0 : idx + 1;
  endfunction

  // occupancy after one cycle of push and pop
  function automatic int unsigned level_after(int unsigned lvl, logic push, logic pop);
    return lvl + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty
);
  import rxf_pkg::*;
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] level;
  logic          pop_ok;

  assign full   = (level == CW'(DEPTH));
  assign empty  = (level == '0);
  assign pop_ok = pop && !empty;
  assign head   = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (push)   wr_ptr <= PW'(wrap_inc(32'(wr_ptr), DEPTH));
      if (pop_ok) rd_ptr <= PW'(wrap_inc(32'(rd_ptr), DEPTH));
      level <= CW'(level_after(32'(level), push, pop_ok));
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  // R3
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);
  // R11
  empty_pop_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> (rd_ptr == $past(rd_ptr)));
endmodule

// File: rtl/rxf_ovr_flag.sv
module rxf_ovr_flag #(
  parameter int unsigned SW      = 16,
  parameter int unsigned OVR_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ovr_evt,
  input  logic          sts_rd,
  input  logic          sts_wr,
  input  logic [SW-1:0] sts_wdata,
  output logic          ovr,
  output logic [SW-1:0] sts_rdata
);
  localparam logic [SW-1:0] CLR_MASK = SW'(1) << OVR_BIT;

  logic seen;
  logic clr_evt;
  logic set_evt;

  assign clr_evt   = sts_wr && seen && ((sts_wdata & CLR_MASK) == '0);
  assign set_evt   = ovr_evt && !ovr;
  assign sts_rdata = ovr ? CLR_MASK : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr  <= 1'b0;
      seen <= 1'b0;
    end else begin
      if (clr_evt)      ovr <= 1'b0;
      else if (set_evt) ovr <= 1'b1;
      if (sts_wr)             seen <= 1'b0;
      else if (sts_rd && ovr) seen <= 1'b1;
    end
  end

  // R6
  clear_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr) |-> $past(sts_wr && seen));
  // R5
  rise_only_by_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(ovr_evt));
  // R2
  set_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> ovr);
  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sts_rdata) <= 1);
endmodule

// File: rtl/rx_fifo_ovr.sv
module rx_fifo_ovr #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned SW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          rx_strobe,
  input  logic [DW-1:0] rx_byte,
  input  logic          dat_pop,
  output logic [DW-1:0] dat_rdata,
  output logic          rx_avail,
  input  logic          sts_rd,
  input  logic          sts_wr,
  input  logic [SW-1:0] sts_wdata,
  output logic [SW-1:0] sts_rdata
);
  logic full, empty, ovr;
  logic byte_in;
  logic push_ok;
  logic ovr_evt;
  logic pop_ok;

  assign byte_in = rx_strobe && rx_en && !ovr;
  assign pop_ok  = dat_pop && !empty;
  assign push_ok = byte_in && (!full || pop_ok);
  assign ovr_evt = byte_in && full && !pop_ok;
  assign rx_avail = !empty;

  rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .push_data(rx_byte),
    .pop(dat_pop), .head(dat_rdata), .full(full), .empty(empty)
  );

  rxf_ovr_flag #(.SW(SW), .OVR_BIT(0)) u_flag (
    .clk(clk), .rst_n(rst_n), .ovr_evt(ovr_evt), .sts_rd(sts_rd),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .ovr(ovr), .sts_rdata(sts_rdata)
  );

  // R4
  stall_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> !push_ok);
  // R8
  disabled_flag_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !sts_wr) |=> $stable(ovr));
  // R10
  pop_push_full_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop_ok) |-> !ovr_evt);
endmodule

// File: tb/rx_fifo_ovr_bench.sv
module rx_fifo_ovr_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic rx_en = 0, rx_strobe = 0, dat_pop = 0, sts_rd = 0, sts_wr = 0;
  logic [7:0] rx_byte = '0;
  logic [15:0] sts_wdata = '0;
  logic [7:0] dat_rdata;
  logic rx_avail;
  logic [15:0] sts_rdata;

  int n_tests = 0, n_fail = 0;
  logic [7:0] q[$];
  logic ovr_m = 0, seen_m = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_ovr u_rx_fifo_ovr (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_strobe(rx_strobe),
    .rx_byte(rx_byte), .dat_pop(dat_pop), .dat_rdata(dat_rdata),
    .rx_avail(rx_avail), .sts_rd(sts_rd), .sts_wr(sts_wr),
    .sts_wdata(sts_wdata), .sts_rdata(sts_rdata)
  );

  function automatic logic [7:0] exp_head();
    return (q.size() > 0) ? q[0] : 8'h00;
  endfunction

  function automatic logic [15:0] exp_sts();
    return {15'b0, ovr_m};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one cycle: drive after negedge, check outputs, advance the model at the edge
  task automatic cyc(input logic s, input logic [7:0] b, input logic e, input logic p,
                     input logic sr, input logic sw, input logic [15:0] wd);
    logic pop_ok, push_ok, set_ok, clr_ok;
    rx_strobe = s; rx_byte = b; rx_en = e; dat_pop = p;
    sts_rd = sr; sts_wr = sw; sts_wdata = wd;
    #1;
    chk("R1 head", 32'(dat_rdata), 32'(exp_head()));
    chk("R1 avail", 32'(rx_avail), 32'(q.size() > 0));
    chk("R9 status", 32'(sts_rdata), 32'(exp_sts()));
    pop_ok  = p && q.size() > 0;
    push_ok = s && e && !ovr_m && (q.size() < 16 || pop_ok);
    set_ok  = s && e && !ovr_m && q.size() == 16 && !pop_ok;
    clr_ok  = sw && seen_m && !wd[0];
    @(posedge clk);
    if (pop_ok) void'(q.pop_front());
    if (push_ok) q.push_back(b);
    if (sw) seen_m = 0; else if (sr && ovr_m) seen_m = 1;
    if (clr_ok) ovr_m = 0; else if (set_ok) ovr_m = 1;
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b); cyc(1, b, 1, 0, 0, 0, 16'h0); endtask
  task automatic pop1(); cyc(0, 8'h0, 1, 1, 0, 0, 16'h0); endtask
  task automatic idle(); cyc(0, 8'h0, 1, 0, 0, 0, 16'h0); endtask
  task automatic srd(); cyc(0, 8'h0, 1, 0, 1, 0, 16'h0); endtask
  task automatic swr(input logic [15:0] v); cyc(0, 8'h0, 1, 0, 0, 1, v); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    int cnt;
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    #1;
    chk("R7 avail", 32'(rx_avail), 0);
    chk("R7 status", 32'(sts_rdata), 0);
    chk("R7 data", 32'(dat_rdata), 0);
    rst_n = 1;
    @(negedge clk);

    // R11 empty pop
    pop1();
    chk("R11 data after empty pop", 32'(dat_rdata), 0);
    push(8'h5A);
    chk("R11 next byte", 32'(dat_rdata), 32'h5A);
    pop1();

    // fill to 16
    for (int i = 0; i < 16; i++) push(8'(i + 1));
    chk("R1 full avail", 32'(rx_avail), 1);
    // R10 pop+push while full
    cyc(1, 8'hEE, 1, 1, 0, 0, 16'h0);
    chk("R10 no overrun", 32'(sts_rdata[0]), 0);
    chk("R10 head advanced", 32'(dat_rdata), 32'h02);
    // R2 overrun
    push(8'hBB);
    chk("R2 flag set", 32'(sts_rdata[0]), 1);
    chk("R3 head kept", 32'(dat_rdata), 32'h02);
    // R4 stall after freeing space
    pop1();
    push(8'h77);
    chk("R4 flag held", 32'(sts_rdata[0]), 1);
    // R8 disabled strobes
    cyc(1, 8'h66, 0, 0, 0, 0, 16'h0);
    chk("R8 flag unchanged", 32'(sts_rdata[0]), 1);
    // R5 write 1
    swr(16'hFFFF);
    chk("R5 write one", 32'(sts_rdata[0]), 1);
    // R6 write 0 without read
    swr(16'h0000);
    chk("R6 no prior read", 32'(sts_rdata[0]), 1);
    srd(); swr(16'h0001); swr(16'h0000);
    chk("R6 read consumed", 32'(sts_rdata[0]), 1);
    srd(); swr(16'hFFFE);
    chk("R6 cleared", 32'(sts_rdata[0]), 0);
    chk("R9 reserved zero", 32'(sts_rdata), 0);
    // drain: expect 3..16 then EE
    cnt = 0;
    while (rx_avail && cnt < 40) begin
      got = dat_rdata;
      pop1();
      cnt++;
    end
    chk("R3 kept count", 32'(cnt), 15);
    chk("R4 last stored byte", 32'(got), 32'hEE);
    // R8 with flag clear
    cyc(1, 8'h44, 0, 0, 0, 0, 16'h0);
    chk("R8 not stored", 32'(rx_avail), 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom;
      cyc(r[2:0] < 3, 8'($urandom), r[7:3] != 0, r[11:8] < 4,
          r[15:12] < 3, r[19:16] == 0, {15'($urandom), r[20]});
    end
    idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule